// File: doc/BRIEF.md
# Batched Sector Erase Scheduler

This block takes already-decoded sector-erase commands and gathers the sectors they name into one erase batch. The first erase command opens a collection window whose length is a parameter in clock cycles. Every further erase command accepted while the window is open adds its sector to the batch and starts the window again. When the window runs out, the block works through the selected sectors in ascending index order. For each sector it first requests a program-to-zero pass and then an erase pass from an external array engine. The engine answers each request with a done or a fail pulse.

The batch can be suspended so that software can read sectors outside the batch, and then resumed. The block drives the status flags a host polls:
- a window-closed flag that is low while the window is still collecting and high once erasing has begun;
- a toggle flag that flips on each status read while the block is busy;
- an error flag for an operation that keeps failing;
- a complete flag.

A per-sector indication tells the read path whether a read returns status or array data.

Top module: `erase_sched`

## Requirements
- R1: After reset, `st_complete` is 1 and `st_window_closed`, `st_error`, `st_suspended` and `op_start` are 0. An erase command in idle opens the window, so `st_complete` reads 0 from the next cycle.
- R2: When an erase command is accepted in cycle c, the window closes and `st_window_closed` rises in cycle c+TIMEOUT_CYC+1, provided no further erase command arrives. An erase command accepted while the window is open adds its sector to the batch and restarts this count.
- R3: `st_window_closed` is 0 in idle and while the window is open. It is 1 from window expiry until the batch ends, and this includes suspension.
- R4: A reset or other command during the window aborts the batch. `st_complete` returns to 1 on the next cycle and no operation is started. Suspend and resume are ignored during the window.
- R5: Sectors are handled in ascending index order. Each sector gets a program-to-zero request (`op_kind`=0) and then an erase request (`op_kind`=1). Each request is a one-cycle `op_start` pulse with `op_sector` valid. The erase done of the last sector sets `st_complete` on the next cycle.
- R6: An `op_fail` makes the block reissue the same request. After MAX_TRIES consecutive failures of one request, `st_error` is set to 1, the batch is dropped and the block goes idle. `st_error` is cleared by a reset command or by a new accepted erase command.
- R7: While erasing, only suspend and reset are acted on. After suspend, `st_suspended` is 1 and any done or fail from the engine is ignored. Resume reissues the interrupted request. Erase commands during suspension are ignored.
- R8: A reset command during erasing or suspension ends the batch, and `st_complete` is 1 on the next cycle.
- R9: `st_toggle` flips on each `stat_rd` while the window is open or erasing runs. It holds its value in idle and in suspension.
- R10: `rd_status` is 1 while the window is open or erasing runs, and 0 in idle. In suspension it is 1 only when `rd_sector` is in the batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_erase | input | 1 | Decoded sector-erase command strobe |
| cmd_sector | input | SW | Sector index carried with the erase command |
| cmd_suspend | input | 1 | Erase suspend command strobe |
| cmd_resume | input | 1 | Erase resume command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_other | input | 1 | Any other decoded command strobe |
| op_done | input | 1 | Array engine finished the current request |
| op_fail | input | 1 | Array engine reports the current request failed |
| stat_rd | input | 1 | Host status read strobe |
| rd_sector | input | SW | Sector addressed by the current host read |
| op_start | output | 1 | One-cycle request to the array engine |
| op_kind | output | 1 | 0 = program to zero, 1 = erase |
| op_sector | output | SW | Sector of the current request |
| st_window_closed | output | 1 | 0 while collecting, 1 once erasing has begun |
| st_toggle | output | 1 | Flips on status reads while busy |
| st_error | output | 1 | Repeated failure flag |
| st_complete | output | 1 | 1 when no batch is in progress |
| st_suspended | output | 1 | Batch is suspended |
| rd_status | output | 1 | Read at rd_sector returns status, not array data |

## Verification
The assertions assume that command strobes are one-cycle pulses and that at most one of them is high in any cycle. They also assume that `op_done` and `op_fail` never arrive in the same cycle. The bench drives each command through its own pulse task, one at a time. Its engine model answers a request only after a fixed latency, and only with one of the two pulses. Engine answers that fall into a suspension are still generated, so the bench exercises the ignore rule.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_RUN  = 2'd2,
    ST_SUSP = 2'd3
  } sched_state_t;

  typedef enum logic {
    PH_ZERO  = 1'b0,
    PH_ERASE = 1'b1
  } phase_t;
endpackage

// File: rtl/erase_window_timer.sv
module erase_window_timer #(
  parameter int CYCLES = 16,
  parameter int CW     = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= CW'(CYCLES - 1);
    else if (run && cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/erase_sector_pick.sv
module erase_sector_pick #(
  parameter int NSECT = 8,
  parameter int SW    = $clog2(NSECT)
) (
  input  logic [NSECT-1:0] req,
  output logic [SW-1:0]    idx
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (req[i]) idx = SW'(i);
    end
  end
endmodule

// File: rtl/erase_sched.sv
module erase_sched #(
  parameter int NSECT       = 8,
  parameter int TIMEOUT_CYC = 16,
  parameter int MAX_TRIES   = 3,
  localparam int SW         = $clog2(NSECT),
  localparam int TRW        = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_erase,
  input  logic [SW-1:0] cmd_sector,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic          cmd_reset,
  input  logic          cmd_other,
  input  logic          op_done,
  input  logic          op_fail,
  input  logic          stat_rd,
  input  logic [SW-1:0] rd_sector,
  output logic          op_start,
  output logic          op_kind,
  output logic [SW-1:0] op_sector,
  output logic          st_window_closed,
  output logic          st_toggle,
  output logic          st_error,
  output logic          st_complete,
  output logic          st_suspended,
  output logic          rd_status
);
  import erase_sched_pkg::*;

  sched_state_t     state;
  phase_t           phase;
  logic [NSECT-1:0] mask;
  logic [NSECT-1:0] sec_onehot;
  logic [NSECT-1:0] cur_onehot;
  logic [NSECT-1:0] mask_clr;
  logic [NSECT-1:0] pick_src;
  logic [SW-1:0]    cur;
  logic [SW-1:0]    pick_idx;
  logic [TRW-1:0]   tries;
  logic             pend;
  logic             err;
  logic             tog;
  logic             tmr_zero;
  logic             tmr_load;
  logic             win_abort;

  for (genvar g = 0; g < NSECT; g++) begin : g_dec
    assign sec_onehot[g] = (cmd_sector == SW'(g));
    assign cur_onehot[g] = (cur == SW'(g));
  end

  assign mask_clr  = mask & ~cur_onehot;
  assign pick_src  = (state == ST_WIN) ? mask : mask_clr;
  assign win_abort = cmd_reset | cmd_other;
  assign tmr_load  = cmd_erase & ((state == ST_IDLE) | ((state == ST_WIN) & ~win_abort));

  erase_sector_pick #(.NSECT(NSECT), .SW(SW)) i_pick (
    .req (pick_src),
    .idx (pick_idx)
  );

  erase_window_timer #(.CYCLES(TIMEOUT_CYC)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .run     (state == ST_WIN),
    .expired (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_ZERO;
      mask     <= '0;
      cur      <= '0;
      tries    <= '0;
      pend     <= 1'b0;
      err      <= 1'b0;
      tog      <= 1'b0;
      op_start <= 1'b0;
    end else begin
      op_start <= 1'b0;
      if (stat_rd && (state == ST_WIN || state == ST_RUN)) tog <= ~tog;
      unique case (state)
        ST_IDLE: begin
          if (cmd_erase) begin
            state <= ST_WIN;
            mask  <= sec_onehot;
            err   <= 1'b0;
          end else if (cmd_reset) begin
            err <= 1'b0;
          end
        end
        ST_WIN: begin
          if (win_abort) begin
            state <= ST_IDLE;
            mask  <= '0;
          end else if (cmd_erase) begin
            mask <= mask | sec_onehot;
          end else if (tmr_zero) begin
            state <= ST_RUN;
            cur   <= pick_idx;
            phase <= PH_ZERO;
            pend  <= 1'b1;
            tries <= '0;
          end
        end
        ST_RUN: begin
          if (cmd_reset) begin
            state <= ST_IDLE;
            mask  <= '0;
            err   <= 1'b0;
          end else if (cmd_suspend) begin
            state <= ST_SUSP;
            pend  <= 1'b1;
          end else if (pend) begin
            op_start <= 1'b1;
            pend     <= 1'b0;
          end else if (op_done) begin
            tries <= '0;
            if (phase == PH_ZERO) begin
              phase <= PH_ERASE;
              pend  <= 1'b1;
            end else begin
              mask <= mask_clr;
              if (mask_clr == '0) begin
                state <= ST_IDLE;
              end else begin
                cur   <= pick_idx;
                phase <= PH_ZERO;
                pend  <= 1'b1;
              end
            end
          end else if (op_fail) begin
            if (tries == TRW'(MAX_TRIES - 1)) begin
              err   <= 1'b1;
              state <= ST_IDLE;
              mask  <= '0;
            end else begin
              tries <= tries + TRW'(1);
              pend  <= 1'b1;
            end
          end
        end
        ST_SUSP: begin
          if (cmd_reset) begin
            state <= ST_IDLE;
            mask  <= '0;
            err   <= 1'b0;
          end else if (cmd_resume) begin
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign op_kind          = (phase == PH_ERASE);
  assign op_sector        = cur;
  assign st_window_closed = (state == ST_RUN) || (state == ST_SUSP);
  assign st_toggle        = tog;
  assign st_error         = err;
  assign st_complete      = (state == ST_IDLE);
  assign st_suspended     = (state == ST_SUSP);
  assign rd_status        = (state == ST_WIN) || (state == ST_RUN) ||
                            ((state == ST_SUSP) && mask[rd_sector]);
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk (
  input logic clk,
  input logic rst,
  input logic cmd_erase,
  input logic cmd_suspend,
  input logic cmd_reset,
  input logic cmd_other,
  input logic op_fail,
  input logic stat_rd,
  input logic op_start,
  input logic op_kind,
  input logic st_window_closed,
  input logic st_toggle,
  input logic st_error,
  input logic st_complete,
  input logic st_suspended
);
  assert_restart_open_R2: assert property (@(posedge clk) disable iff (rst)
    (!st_complete && !st_window_closed && cmd_erase && !cmd_reset && !cmd_other)
      |=> !st_window_closed);

  assert_close_from_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(st_window_closed) |-> $past(!st_complete && !st_window_closed));

  assert_abort_window_R4: assert property (@(posedge clk) disable iff (rst)
    (!st_complete && !st_window_closed && (cmd_reset || cmd_other)) |=> st_complete);

  assert_start_when_running_R5: assert property (@(posedge clk) disable iff (rst)
    op_start |-> (st_window_closed && !st_suspended));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);

  assert_zero_pass_first_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(st_window_closed) && !cmd_suspend && !cmd_reset) |=> (op_start && !op_kind));

  assert_error_from_fail_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(st_error) |-> $past(op_fail));

  assert_quiet_in_suspend_R7: assert property (@(posedge clk) disable iff (rst)
    st_suspended |-> !op_start);

  assert_toggle_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_toggle) |-> $past(stat_rd));
endmodule

bind erase_sched erase_sched_chk i_chk (.*);

// File: tb/test_erase_sched.sv
module test_erase_sched;
  localparam int NS   = 8;
  localparam int T    = 6;
  localparam int MAXT = 3;
  localparam int LAT  = 3;
  localparam int SW   = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0, cmd_other = 0;
  logic [SW-1:0] cmd_sector = '0;
  logic op_done = 0, op_fail = 0, stat_rd = 0;
  logic [SW-1:0] rd_sector = '0;
  logic op_start, op_kind, st_window_closed, st_toggle, st_error, st_complete, st_suspended, rd_status;
  logic [SW-1:0] op_sector;

  always #4 clk = ~clk;

  erase_sched #(.NSECT(NS), .TIMEOUT_CYC(T), .MAX_TRIES(MAXT)) i_erase_sched (.*);

  int nchecks = 0;
  int nfail   = 0;

  task automatic chk(input int act, input int exp, input string what);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st = 0, m_left = 0, m_cur = 0, m_ph = 0, m_tries = 0;
  bit m_pend = 0, m_err = 0, m_tog = 0, m_start = 0;
  bit [NS-1:0] m_mask = '0;

  function automatic int lowest(bit [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_left = 0; m_cur = 0; m_ph = 0; m_tries = 0;
      m_pend = 0; m_err = 0; m_tog = 0; m_start = 0; m_mask = '0;
    end else begin
      m_start = 0;
      if (stat_rd && (m_st == 1 || m_st == 2)) m_tog = !m_tog;
      case (m_st)
        0: if (cmd_erase) begin
             m_st = 1; m_mask = '0; m_mask[cmd_sector] = 1'b1; m_left = T; m_err = 0;
           end else if (cmd_reset) m_err = 0;
        1: if (cmd_reset || cmd_other) begin m_st = 0; m_mask = '0; end
           else if (cmd_erase) begin m_mask[cmd_sector] = 1'b1; m_left = T; end
           else if (m_left == 1) begin
             m_st = 2; m_cur = lowest(m_mask); m_ph = 0; m_pend = 1; m_tries = 0;
           end else m_left--;
        2: if (cmd_reset) begin m_st = 0; m_mask = '0; m_err = 0; end
           else if (cmd_suspend) begin m_st = 3; m_pend = 1; end
           else if (m_pend) begin m_start = 1; m_pend = 0; end
           else if (op_done) begin
             m_tries = 0;
             if (m_ph == 0) begin m_ph = 1; m_pend = 1; end
             else begin
               m_mask[m_cur] = 1'b0;
               if (m_mask == '0) m_st = 0;
               else begin m_cur = lowest(m_mask); m_ph = 0; m_pend = 1; end
             end
           end else if (op_fail) begin
             m_tries++;
             if (m_tries == MAXT) begin m_err = 1; m_st = 0; m_mask = '0; end
             else m_pend = 1;
           end
        default: if (cmd_reset) begin m_st = 0; m_mask = '0; m_err = 0; end
                 else if (cmd_resume) m_st = 2;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(st_complete, (m_st == 0), "R1 st_complete vs model");
      chk(st_window_closed, (m_st == 2 || m_st == 3), "R3 st_window_closed vs model");
      chk(st_suspended, (m_st == 3), "R7 st_suspended vs model");
      chk(op_start, m_start, "R5 op_start vs model");
      if (m_start) begin
        chk(op_kind, m_ph, "R5 op_kind vs model");
        chk(op_sector, m_cur, "R5 op_sector vs model");
      end
      chk(st_error, m_err, "R6 st_error vs model");
      chk(st_toggle, m_tog, "R9 st_toggle vs model");
      chk(rd_status, (m_st == 1 || m_st == 2) || (m_st == 3 && m_mask[rd_sector]),
          "R10 rd_status vs model");
    end
  end

  // ---------------- engine model ----------------
  int eng_cnt = 0;
  int fail_budget = 0;
  int ers_q[$];
  int starts = 0;

  always @(negedge clk) begin
    op_done = 0;
    op_fail = 0;
    if (op_start) begin
      eng_cnt = LAT;
      starts++;
      if (op_kind) ers_q.push_back(int'(op_sector));
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        if (op_kind && fail_budget > 0) begin op_fail = 1; fail_budget--; end
        else op_done = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic erase(input int s);
    cmd_erase = 1; cmd_sector = SW'(s);
    @(negedge clk);
    cmd_erase = 0;
  endtask

  task automatic pulse_suspend(); cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; endtask
  task automatic pulse_resume();  cmd_resume  = 1; @(negedge clk); cmd_resume  = 0; endtask
  task automatic pulse_reset();   cmd_reset   = 1; @(negedge clk); cmd_reset   = 0; endtask
  task automatic pulse_other();   cmd_other   = 1; @(negedge clk); cmd_other   = 0; endtask
  task automatic read_status();   stat_rd     = 1; @(negedge clk); stat_rd     = 0; endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !st_complete; i++) @(negedge clk);
  endtask

  task automatic wait_closed();
    for (int i = 0; i < 2000 && !st_window_closed; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int tg;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(st_complete, 1, "R1 reset complete");
    chk(st_window_closed, 0, "R3 reset window flag");
    chk(st_error, 0, "R1 reset error");
    chk(op_start, 0, "R1 reset op_start");

    // R9: reads while idle leave the toggle alone
    tg = st_toggle;
    read_status();
    chk(st_toggle, tg, "R9 idle read no toggle");

    // single sector, status reads during window and run
    erase(3);
    chk(st_complete, 0, "R1 window opened");
    read_status();
    read_status();
    read_status();
    wait_closed();
    read_status();
    wait_idle();
    chk(ers_q.size(), 1, "R5 single erase count");
    if (ers_q.size() > 0) chk(ers_q[0], 3, "R5 single erase sector");
    ers_q.delete();

    // R2: restart and batch collection, ascending order
    erase(5);
    tick(3);
    erase(7);
    tick(2);
    erase(2);
    tick(T - 1);
    chk(st_window_closed, 0, "R2 window still open");
    @(negedge clk);
    chk(st_window_closed, 1, "R2 window closed on time");
    wait_idle();
    chk(ers_q.size(), 3, "R5 batch size");
    if (ers_q.size() == 3) begin
      chk(ers_q[0], 2, "R5 order first");
      chk(ers_q[1], 5, "R5 order second");
      chk(ers_q[2], 7, "R5 order third");
    end
    ers_q.delete();

    // R4: suspend ignored in window, other command aborts
    starts = 0;
    erase(1);
    tick(1);
    pulse_suspend();
    chk(st_suspended, 0, "R4 suspend ignored in window");
    pulse_other();
    chk(st_complete, 1, "R4 abort to idle");
    tick(2 * T);
    chk(starts, 0, "R4 no operation after abort");

    // R7 / R10: suspend during erase
    erase(0);
    erase(4);
    wait_closed();
    pulse_other();
    pulse_resume();
    for (int i = 0; i < 200 && !(op_start && op_kind && op_sector == 0); i++) @(negedge clk);
    pulse_suspend();
    chk(st_suspended, 1, "R7 suspended");
    rd_sector = 4;
    @(negedge clk);
    chk(rd_status, 1, "R10 batch sector reads status");
    rd_sector = 6;
    @(negedge clk);
    chk(rd_status, 0, "R10 outside sector reads data");
    erase(6);
    chk(rd_status, 0, "R7 erase ignored while suspended");
    tg = st_toggle;
    read_status();
    chk(st_toggle, tg, "R9 suspended read no toggle");
    tick(LAT + 2);
    pulse_resume();
    chk(st_suspended, 0, "R7 resumed");
    wait_idle();
    chk(ers_q.size(), 3, "R7 reissued erase count");
    if (ers_q.size() == 3) begin
      chk(ers_q[0], 0, "R7 first issue");
      chk(ers_q[1], 0, "R7 reissue same sector");
      chk(ers_q[2], 4, "R7 continue batch");
    end
    ers_q.delete();
    rd_sector = 0;
    @(negedge clk);
    chk(rd_status, 0, "R10 idle reads data");

    // R6: persistent failure
    fail_budget = MAXT;
    erase(2);
    wait_idle();
    chk(st_error, 1, "R6 error after max tries");
    chk(ers_q.size(), MAXT, "R6 attempts made");
    ers_q.delete();
    erase(2);
    chk(st_error, 0, "R6 new erase clears error");
    fail_budget = 1;
    wait_idle();
    chk(st_error, 0, "R6 single retry recovers");
    chk(ers_q.size(), 2, "R6 retry count");
    ers_q.delete();

    // R6: reset command clears error
    fail_budget = MAXT;
    erase(6);
    wait_idle();
    pulse_reset();
    chk(st_error, 0, "R6 reset clears error");

    // R8: reset during run
    erase(3);
    wait_closed();
    tick(2);
    pulse_reset();
    chk(st_complete, 1, "R8 reset during run");
    chk(st_window_closed, 0, "R8 window flag low");
    tick(LAT + 2);

    // R8: reset during suspend
    erase(5);
    wait_closed();
    pulse_suspend();
    pulse_reset();
    chk(st_complete, 1, "R8 reset during suspend");
    chk(st_suspended, 0, "R8 suspend cleared");
    tick(LAT + 2);

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule